// File: doc/BRIEF.md
# Dataflow Instruction Scheduler

This block decides which instructions of a program graph are ready to run. Every instruction slot carries a ready flag and a small signal counter. A ready slot is offered to an execution pipeline outside the block as a slot index on a valid/ready fire port. When the pipeline reports a finished slot on the done port, the block looks up that slot's successor links and counts one signal against each successor. A successor whose counter reaches zero becomes ready.

A slot can be marked as part of a sequential thread. When such a slot completes, its first successor becomes ready at once through a shortcut, and no count is taken. The graph is loaded slot by slot through a configuration write port before a start pulse. Firing a slot reloads its counter, so the same graph can be driven again in a pipelined fashion. The operation datapath and operand storage are handled elsewhere.

Top module: `dfsched_top`

## Requirements
- R1: After reset, fire_valid is 0, idle is 1, and every slot waits.
- R2: A configuration write stores four things for the addressed slot: a 3-bit required count, two successor indices each with a valid bit, and a sequential bit. On a start pulse, every counter loads its configured count, and the slots with a count of 0 become ready. Unwritten slots default to count 7 with no successors.
- R3: Once fire_valid is raised, it stays high with fire_slot unchanged until fire_ready is sampled high. At most one slot is issued per cycle.
- R4: When several slots are ready, the lowest-numbered one is issued first.
- R5: A done for a non-sequential slot takes one signal off the counter of each valid successor. The successor becomes ready only when its counter reaches zero, so a count of 2 needs two dones.
- R6: A done sampled at a clock edge is applied before the next slot is chosen. With the fire register free, a successor enabled by that done is shown on fire_valid/fire_slot just after that same edge.
- R7: A done for a slot whose sequential bit is set makes its first successor ready directly and leaves that successor's counter alone. Its second successor link is ignored.
- R8: Issuing a slot clears its ready flag and reloads its counter with the configured count, so the slot can be enabled again by later dones.
- R9: A signal that reaches a waiting slot whose counter is already 0 is ignored. The counter does not wrap, and the slot does not become ready.
- R10: idle is 1 exactly when no slot is ready, fire_valid is 0, and no issued slot is still awaiting its done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_slot | input | 5 | Slot being configured |
| cfg_count | input | 3 | Required signal count |
| cfg_succ0 | input | 5 | First successor index |
| cfg_succ0_vld | input | 1 | First successor present |
| cfg_succ1 | input | 5 | Second successor index |
| cfg_succ1_vld | input | 1 | Second successor present |
| cfg_seq | input | 1 | Sequential-thread (shortcut) bit |
| start | input | 1 | Load counters and enable count-0 slots |
| fire_valid | output | 1 | A slot is offered for issue |
| fire_ready | input | 1 | Pipeline accepts the offered slot |
| fire_slot | output | 5 | Offered slot index |
| done_valid | input | 1 | Pipeline reports a completion |
| done_slot | input | 5 | Completed slot index |
| idle | output | 1 | Nothing ready, pending or in flight |

## Verification
The main function is exercised with a diamond graph, where one source fans out to two slots that join in a slot with count 2. This shows that fan-out releases both slots in index order and that the join holds back after only one of its two dones. The same graph is then driven a second time with no new start, which separates reloading on issue from a one-shot count. A done aimed at an already-zero source shows that saturation is not wrap-around. A sequential slot whose second link points at a count-1 slot shows that the shortcut releases only the first successor. Holding fire_ready low while two slots are ready shows that the offer holds and that lower indices take priority.

// File: rtl/dfs_pkg.sv
package dfs_pkg;
  localparam int SLOTS_DEF = 32;
  localparam int CNT_W_DEF = 3;

  // link flags held per slot beside the successor indices
  typedef struct packed {
    logic seq;   // sequential-thread shortcut
    logic v1;    // second successor present
    logic v0;    // first successor present
  } link_flags_t;
endpackage

// File: rtl/dfs_cfg_mem.sv
module dfs_cfg_mem
  import dfs_pkg::*;
#(
  parameter int SLOTS = SLOTS_DEF,
  parameter int CNT_W = CNT_W_DEF,
  localparam int IDX_W = $clog2(SLOTS)
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          we,
  input  logic [IDX_W-1:0]              waddr,
  input  logic [CNT_W-1:0]              wcount,
  input  logic [IDX_W-1:0]              wsucc0,
  input  logic [IDX_W-1:0]              wsucc1,
  input  link_flags_t                   wflags,
  input  logic [IDX_W-1:0]              raddr,
  output logic [IDX_W-1:0]              rsucc0,
  output logic [IDX_W-1:0]              rsucc1,
  output link_flags_t                   rflags,
  output logic [SLOTS-1:0][CNT_W-1:0]   init_vec
);
  // successor tables: plain memories, asynchronous read (distributed RAM)
  logic [IDX_W-1:0] succ0_mem [SLOTS];
  logic [IDX_W-1:0] succ1_mem [SLOTS];
  link_flags_t      flags_q   [SLOTS];
  logic [SLOTS-1:0][CNT_W-1:0] init_q;

  always_ff @(posedge clk) begin
    if (we) begin
      succ0_mem[waddr] <= wsucc0;
      succ1_mem[waddr] <= wsucc1;
    end
  end

  // flags and counts need a defined reset value so unwritten slots stay inert
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < SLOTS; i++) begin
        flags_q[i] <= '0;
        init_q[i]  <= '1;
      end
    end else if (we) begin
      flags_q[waddr] <= wflags;
      init_q[waddr]  <= wcount;
    end
  end

  assign rsucc0   = succ0_mem[raddr];
  assign rsucc1   = succ1_mem[raddr];
  assign rflags   = flags_q[raddr];
  assign init_vec = init_q;
endmodule

// File: rtl/dfs_sync_array.sv
module dfs_sync_array
  import dfs_pkg::*;
#(
  parameter int SLOTS = SLOTS_DEF,
  parameter int CNT_W = CNT_W_DEF,
  localparam int IDX_W = $clog2(SLOTS)
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        start,
  input  logic [SLOTS-1:0][CNT_W-1:0] init_vec,
  input  logic                        done_valid,
  input  logic [IDX_W-1:0]            done_succ0,
  input  logic [IDX_W-1:0]            done_succ1,
  input  link_flags_t                 done_flags,
  input  logic [SLOTS-1:0]            pick,
  output logic [SLOTS-1:0]            en_next,
  output logic [SLOTS-1:0]            en_d
);
  for (genvar i = 0; i < SLOTS; i++) begin : g_slot
    logic [CNT_W-1:0] cnt_q;
    logic             en_q;
    logic             hit0, hit1, shortcut, reach_zero;
    logic [1:0]       dec;

    always_comb begin
      hit0       = done_valid && done_flags.v0 && (done_succ0 == IDX_W'(i));
      hit1       = done_valid && !done_flags.seq && done_flags.v1 &&
                   (done_succ1 == IDX_W'(i));
      shortcut   = hit0 && done_flags.seq;
      dec        = {1'b0, hit0 && !done_flags.seq} + {1'b0, hit1};
      reach_zero = (dec != 2'd0) && (cnt_q != '0) && (cnt_q <= CNT_W'(dec));
      en_next[i] = en_q || shortcut || reach_zero;
      en_d[i]    = start ? (init_vec[i] == '0) : (en_next[i] && !pick[i]);
    end

    always_ff @(posedge clk) begin
      if (rst) begin
        cnt_q <= '0;
        en_q  <= 1'b0;
      end else begin
        en_q <= en_d[i];
        if (start || pick[i])
          cnt_q <= init_vec[i];
        else if (dec != 2'd0)
          cnt_q <= (cnt_q <= CNT_W'(dec)) ? '0 : cnt_q - CNT_W'(dec);
      end
    end

    // R9
    no_underflow_chk: assert property (@(posedge clk) disable iff (rst)
      (cnt_q == '0 && dec != 2'd0 && !start && !pick[i]) |=> (cnt_q == '0));

    // R8
    reload_chk: assert property (@(posedge clk) disable iff (rst)
      (pick[i] && !start) |=> (cnt_q == $past(init_vec[i]) && !en_q));
  end
endmodule

// File: rtl/dfs_pick.sv
module dfs_pick #(
  parameter int SLOTS = 32,
  localparam int IDX_W = $clog2(SLOTS)
) (
  input  logic [SLOTS-1:0] req,
  input  logic             allow,
  output logic [SLOTS-1:0] grant,
  output logic [IDX_W-1:0] idx,
  output logic             any
);
  always_comb begin
    idx = '0;
    any = 1'b0;
    for (int i = SLOTS - 1; i >= 0; i--) begin
      if (req[i]) begin
        idx = IDX_W'(i);
        any = 1'b1;
      end
    end
  end

  // isolate the lowest set bit
  assign grant = allow ? (req & (~req + SLOTS'(1))) : '0;
endmodule

// File: rtl/dfsched_top.sv
module dfsched_top
  import dfs_pkg::*;
#(
  parameter int SLOTS = SLOTS_DEF,
  parameter int CNT_W = CNT_W_DEF,
  localparam int IDX_W = $clog2(SLOTS),
  localparam int FLY_W = IDX_W + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_we,
  input  logic [IDX_W-1:0] cfg_slot,
  input  logic [CNT_W-1:0] cfg_count,
  input  logic [IDX_W-1:0] cfg_succ0,
  input  logic             cfg_succ0_vld,
  input  logic [IDX_W-1:0] cfg_succ1,
  input  logic             cfg_succ1_vld,
  input  logic             cfg_seq,
  input  logic             start,
  output logic             fire_valid,
  input  logic             fire_ready,
  output logic [IDX_W-1:0] fire_slot,
  input  logic             done_valid,
  input  logic [IDX_W-1:0] done_slot,
  output logic             idle
);
  logic [IDX_W-1:0]            d_succ0, d_succ1, pick_idx;
  link_flags_t                 d_flags;
  logic [SLOTS-1:0][CNT_W-1:0] init_vec;
  logic [SLOTS-1:0]            en_next, en_d, grant;
  logic                        pick_any, pick_en, accept;
  logic                        fire_valid_q, fire_valid_d, idle_q, idle_d;
  logic [IDX_W-1:0]            fire_slot_q;
  logic [FLY_W-1:0]            fly_q, fly_d;

  dfs_cfg_mem #(.SLOTS(SLOTS), .CNT_W(CNT_W)) u_cfg (
    .clk(clk), .rst(rst), .we(cfg_we), .waddr(cfg_slot), .wcount(cfg_count),
    .wsucc0(cfg_succ0), .wsucc1(cfg_succ1),
    .wflags('{seq: cfg_seq, v1: cfg_succ1_vld, v0: cfg_succ0_vld}),
    .raddr(done_slot), .rsucc0(d_succ0), .rsucc1(d_succ1), .rflags(d_flags),
    .init_vec(init_vec)
  );

  dfs_sync_array #(.SLOTS(SLOTS), .CNT_W(CNT_W)) u_sync (
    .clk(clk), .rst(rst), .start(start), .init_vec(init_vec),
    .done_valid(done_valid), .done_succ0(d_succ0), .done_succ1(d_succ1),
    .done_flags(d_flags), .pick(grant), .en_next(en_next), .en_d(en_d)
  );

  assign accept  = fire_valid_q && fire_ready;
  assign pick_en = !start && (!fire_valid_q || fire_ready);

  dfs_pick #(.SLOTS(SLOTS)) u_pick (
    .req(en_next), .allow(pick_en), .grant(grant), .idx(pick_idx), .any(pick_any)
  );

  always_comb begin
    if (start)        fire_valid_d = 1'b0;
    else if (pick_en) fire_valid_d = pick_any;
    else              fire_valid_d = fire_valid_q;

    fly_d = fly_q;
    if (start) fly_d = '0;
    else if (accept && !done_valid) fly_d = fly_q + FLY_W'(1);
    else if (!accept && done_valid && fly_q != '0) fly_d = fly_q - FLY_W'(1);

    idle_d = (en_d == '0) && !fire_valid_d && (fly_d == '0);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      fire_valid_q <= 1'b0;
      fire_slot_q  <= '0;
      fly_q        <= '0;
      idle_q       <= 1'b1;
    end else begin
      fire_valid_q <= fire_valid_d;
      if (pick_en && pick_any) fire_slot_q <= pick_idx;
      fly_q  <= fly_d;
      idle_q <= idle_d;
    end
  end

  assign fire_valid = fire_valid_q;
  assign fire_slot  = fire_slot_q;
  assign idle       = idle_q;

  // R3
  hold_offer_chk: assert property (@(posedge clk) disable iff (rst)
    (fire_valid_q && !fire_ready && !start) |=> (fire_valid_q && $stable(fire_slot_q)));

  // R10
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    idle_q |-> !fire_valid_q);

  // R10
  inflight_count_chk: assert property (@(posedge clk) disable iff (rst)
    (accept && !done_valid && !start) |=> (fly_q == FLY_W'($past(fly_q) + FLY_W'(1))));

  // R4
  always_comb begin
    if (!rst) begin
      grant_subset_chk: assert ((grant & ~en_next) == '0 && $onehot0(grant));
    end
  end
endmodule

// File: tb/dfsched_top_tb_top.sv
module dfsched_top_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cfg_we = 1'b0, cfg_succ0_vld = 1'b0, cfg_succ1_vld = 1'b0, cfg_seq = 1'b0;
  logic [4:0] cfg_slot = '0, cfg_succ0 = '0, cfg_succ1 = '0, done_slot = '0;
  logic [2:0] cfg_count = '0;
  logic       start = 1'b0, fire_ready = 1'b1, done_valid = 1'b0;
  logic       fire_valid, idle;
  logic [4:0] fire_slot;

  int checks = 0, failures = 0;
  int fired [0:63];
  int nfired = 0;

  always #5 clk = ~clk;

  dfsched_top dut_i (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_slot(cfg_slot), .cfg_count(cfg_count),
    .cfg_succ0(cfg_succ0), .cfg_succ0_vld(cfg_succ0_vld), .cfg_succ1(cfg_succ1),
    .cfg_succ1_vld(cfg_succ1_vld), .cfg_seq(cfg_seq), .start(start),
    .fire_valid(fire_valid), .fire_ready(fire_ready), .fire_slot(fire_slot),
    .done_valid(done_valid), .done_slot(done_slot), .idle(idle)
  );

  // record each accepted issue; inputs are steady since the previous negedge
  always @(posedge clk) begin
    if (!rst && fire_valid && fire_ready && nfired < 64) begin
      fired[nfired] = int'(fire_slot);
      nfired = nfired + 1;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic cfg_write(input int slot, input int cnt, input int s0, input bit v0,
                           input int s1, input bit v1, input bit seq);
    @(negedge clk);
    cfg_we = 1'b1; cfg_slot = 5'(slot); cfg_count = 3'(cnt);
    cfg_succ0 = 5'(s0); cfg_succ0_vld = v0; cfg_succ1 = 5'(s1); cfg_succ1_vld = v1;
    cfg_seq = seq;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic pulse_start();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
  endtask

  task automatic send_done(input int slot);
    @(negedge clk); done_valid = 1'b1; done_slot = 5'(slot);
    @(negedge clk); done_valid = 1'b0;
  endtask

  task automatic t_reset();
    tick(1);
    chk(fire_valid == 1'b0, "R1 fire_valid after reset", int'(fire_valid), 0);
    chk(idle == 1'b1, "R1 idle after reset", int'(idle), 1);
    tick(3);
    chk(fire_valid == 1'b0, "R1 no slot ready without start", int'(fire_valid), 0);
  endtask

  task automatic t_diamond();
    // 0 -> {1,2}; 1 -> 3; 2 -> 3; 3 (count 2) -> 0
    cfg_write(0, 0, 1, 1, 2, 1, 0);
    cfg_write(1, 1, 3, 1, 0, 0, 0);
    cfg_write(2, 1, 3, 1, 0, 0, 0);
    cfg_write(3, 2, 0, 1, 0, 0, 0);
    fire_ready = 1'b1;
    pulse_start();
    tick(3);
    chk(nfired == 1 && fired[0] == 0, "R2 count-0 source issued after start", fired[0], 0);
    chk(idle == 1'b0, "R10 busy while slot 0 in flight", int'(idle), 0);
    fire_ready = 1'b0;
    send_done(0);
    chk(fire_valid == 1'b1 && fire_slot == 5'd1, "R6 successor offered right after done",
        int'(fire_slot), 1);
    tick(3);
    chk(fire_valid == 1'b1 && fire_slot == 5'd1, "R3 offer held while not ready",
        int'(fire_slot), 1);
    chk(nfired == 1, "R3 nothing issued while not ready", nfired, 1);
    fire_ready = 1'b1;
    tick(3);
    chk(nfired == 3 && fired[1] == 1 && fired[2] == 2, "R4 lowest index first",
        fired[1], 1);
    send_done(1);
    tick(3);
    chk(nfired == 3, "R5 join waits after one signal", nfired, 3);
    send_done(2);
    tick(3);
    chk(nfired == 4 && fired[3] == 3, "R5 join issued after second signal", fired[3], 3);
    chk(idle == 1'b0, "R10 busy while slot 3 in flight", int'(idle), 0);
    send_done(3);
    tick(3);
    chk(nfired == 4, "R9 signal to zero-count source ignored", nfired, 4);
    chk(idle == 1'b1, "R10 idle once graph drained", int'(idle), 1);
  endtask

  task automatic t_rerun();
    send_done(0);
    tick(4);
    chk(nfired == 6 && fired[4] == 1 && fired[5] == 2, "R8 reloaded slots enabled again",
        fired[4], 1);
    send_done(1);
    tick(3);
    chk(nfired == 6, "R8 join counter reloaded to 2", nfired, 6);
    send_done(2);
    tick(3);
    chk(nfired == 7 && fired[6] == 3, "R8 join issued on rerun", fired[6], 3);
    send_done(3);
    tick(3);
    chk(idle == 1'b1, "R10 idle after rerun", int'(idle), 1);
  endtask

  task automatic t_shortcut();
    int base;
    // slot 10 sequential: first successor 11 (count 3), second 12 (count 1) ignored
    cfg_write(10, 0, 11, 1, 12, 1, 1);
    cfg_write(11, 3, 0, 0, 0, 0, 0);
    cfg_write(12, 1, 0, 0, 0, 0, 0);
    base = nfired;
    pulse_start();
    tick(4);
    chk(nfired == base + 2 && fired[base] == 0 && fired[base + 1] == 10,
        "R4 two sources issued in index order", fired[base + 1], 10);
    send_done(10);
    tick(4);
    chk(nfired == base + 3 && fired[base + 2] == 11, "R7 shortcut enables first successor",
        fired[base + 2], 11);
    chk(nfired == base + 3, "R7 second link ignored on shortcut", nfired - base, 3);
  endtask

  initial begin
    tick(3);
    rst = 1'b0;
    t_reset();
    t_diamond();
    t_rerun();
    t_shortcut();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule